// File: doc/BRIEF.md
# Three-Wire Command-Response Serial Slave

This block is the slave end of a serial link where master and slave share a single data line. Chip select is active low. The serial clock rests high. The master sets each bit while the clock is low, and the receiver takes it on the rising edge. Every exchange has two phases in a fixed order. First the slave shifts in a fixed number of command bytes. Then it returns a fixed number of response bytes on the same wire. Each byte travels least significant bit first.

The slave never drives the line high. Its single line control, `lineDriveLow`, either pulls the wire low or releases it, and an external pull-up supplies the high level. The received command is presented on `cmdIndex`, which addresses a small register map outside the block. That map returns the word to send on `rspData`.

Chip select and the serial clock are asynchronous to the system clock. Both pass through two-flop synchronisers, and edges are detected on the synchronised copies. The data input is delayed by the same amount so that it stays aligned with the clock.

Top module: `spi3w_cmd_slave`

## Requirements
- R1: The line is only ever pulled low or released. A response bit of 1 leaves `lineDriveLow` at 0, and a response bit of 0 sets it to 1.
- R2: After chip select falls, the first CMD_BYTES*8 rising clock edges capture `sdIn` as the command, LSB first. The line stays released for the whole receive phase.
- R3: Once the receive phase is over, `cmdIndex` holds the command. The first byte received sits in bits 7:0, the next in bits 15:8, and so on.
- R4: The word presented on `rspData` for that index is sent next, LSB first, as RSP_BYTES*8 bits. Each bit is placed on the line after a falling clock edge and held through the following rising edge.
- R5: While response bits are being sent, `sdIn` is ignored. Neither `cmdIndex` nor the returned bits depend on it.
- R6: A falling chip select clears the byte and bit counters, the partial byte and `cmdIndex` to zero. A new exchange then starts.
- R7: A rising chip select releases the line at once, without waiting for any clock. Any partial byte is dropped, and the next exchange starts afresh.
- R8: Clock edges after the last response bit leave the line released until the next falling chip select.
- R9: A response bit appears on `lineDriveLow` on the third system clock edge after the serial clock falls, and not earlier.
- R10: After reset, the line is released and `cmdIndex` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select from the master, active low, asynchronous |
| sclk | input | 1 | Serial clock from the master, idles high, asynchronous |
| sdIn | input | 1 | Sampled level of the shared data line |
| lineDriveLow | output | 1 | 1 pulls the shared line low; 0 releases it |
| cmdIndex | output | CMD_BYTES*8 | Received command, used as the register map index |
| rspData | input | RSP_BYTES*8 | Register map word for `cmdIndex` |

## Verification
A serial clock edge reaches the state machine on the third system clock edge after the pin changes. The bench therefore holds every serial half period for eight system cycles, and it reads each response bit six cycles after the falling edge, once the value has settled. The R9 latency is pinned down directly: the line must still be released two cycles after a falling edge and must be pulled low at cycle three. The release on chip select removal (R7) is combinational, so it is checked 1 ns after `csN` rises, with no clock in between. `cmdIndex` is checked three cycles or more after the last command rising edge, and checked again after the response phase.

// File: rtl/spi3w_pkg.sv
`timescale 1ns/1ps
package spi3w_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CMD  = 2'd1,
    PH_RSP  = 2'd2,
    PH_DONE = 2'd3
  } phase_e;

  // Control-to-datapath strobes, valid for one system clock cycle each
  typedef struct packed {
    logic clr;        // new exchange: wipe datapath state
    logic shiftIn;    // capture one command bit
    logic storeByte;  // the captured bit completes a command byte
    logic driveBit;   // put the next response bit on the line
    logic firstBit;   // with driveBit: take the word from the register map
    logic relLine;    // release the line
  } strobe_t;

endpackage

// File: rtl/spi3w_sync.sv
`timescale 1ns/1ps
module spi3w_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/spi3w_ctrl.sv
`timescale 1ns/1ps
module spi3w_ctrl
  import spi3w_pkg::*;
#(
  parameter int CMD_BYTES = 2,
  parameter int RSP_BITS  = 16,
  localparam int BYTE_W = (CMD_BYTES > 1) ? $clog2(CMD_BYTES) : 1,
  localparam int RCNT_W = (RSP_BITS > 1) ? $clog2(RSP_BITS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csActive,
  input  logic              csStart,
  input  logic              sclkRise,
  input  logic              sclkFall,
  output strobe_t           stb,
  output logic [BYTE_W-1:0] byteSel,
  output phase_e            phase
);

  localparam logic [BYTE_W-1:0] CMD_LAST = BYTE_W'(CMD_BYTES - 1);
  localparam logic [RCNT_W-1:0] RSP_LAST = RCNT_W'(RSP_BITS - 1);

  phase_e            phaseQ;
  logic [2:0]        bitCnt;
  logic [BYTE_W-1:0] byteCnt;
  logic [RCNT_W-1:0] rspCnt;

  assign phase   = phaseQ;
  assign byteSel = byteCnt;

  always_comb begin
    stb = '0;
    if (!csActive) begin
      stb.relLine = 1'b1;
    end else if (csStart) begin
      stb.clr = 1'b1;
    end else begin
      unique case (phaseQ)
        PH_CMD: begin
          if (sclkRise) begin
            stb.shiftIn   = 1'b1;
            stb.storeByte = (bitCnt == 3'd7);
          end
        end
        PH_RSP: begin
          if (sclkFall) begin
            stb.driveBit = 1'b1;
            stb.firstBit = (rspCnt == '0);
          end else if (sclkRise && rspCnt == RSP_LAST) begin
            stb.relLine = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ  <= PH_IDLE;
      bitCnt  <= '0;
      byteCnt <= '0;
      rspCnt  <= '0;
    end else if (!csActive) begin
      phaseQ <= PH_IDLE;
    end else if (csStart) begin
      phaseQ  <= PH_CMD;
      bitCnt  <= '0;
      byteCnt <= '0;
      rspCnt  <= '0;
    end else begin
      unique case (phaseQ)
        PH_CMD: begin
          if (sclkRise) begin
            bitCnt <= bitCnt + 3'd1;
            if (bitCnt == 3'd7) begin
              if (byteCnt == CMD_LAST) begin
                phaseQ <= PH_RSP;
                rspCnt <= '0;
              end else begin
                byteCnt <= byteCnt + 1'b1;
              end
            end
          end
        end
        PH_RSP: begin
          if (sclkRise) begin
            if (rspCnt == RSP_LAST) phaseQ <= PH_DONE;
            else                    rspCnt <= rspCnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/spi3w_dp.sv
`timescale 1ns/1ps
module spi3w_dp
  import spi3w_pkg::*;
#(
  parameter int CMD_BYTES = 2,
  parameter int RSP_BITS  = 16,
  localparam int BYTE_W   = (CMD_BYTES > 1) ? $clog2(CMD_BYTES) : 1,
  localparam int CMD_BITS = CMD_BYTES * 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [BYTE_W-1:0]   byteSel,
  input  logic                sdS,
  input  logic [RSP_BITS-1:0] rspData,
  output logic [CMD_BITS-1:0] cmdIndex,
  output logic                driveLow
);

  logic [6:0]          shIn;
  logic [7:0]          nextByte;
  logic [CMD_BITS-1:0] cmdBuf;
  logic [RSP_BITS-1:0] rspSh;
  logic [RSP_BITS-1:0] rspWord;
  logic                driveQ;

  // LSB first: each new bit enters at the top and walks down
  assign nextByte = {sdS, shIn};
  assign rspWord  = stb.firstBit ? rspData : rspSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shIn   <= '0;
      cmdBuf <= '0;
      rspSh  <= '0;
      driveQ <= 1'b0;
    end else if (stb.clr) begin
      shIn   <= '0;
      cmdBuf <= '0;
      rspSh  <= '0;
      driveQ <= 1'b0;
    end else begin
      if (stb.shiftIn) shIn <= nextByte[7:1];
      if (stb.storeByte) cmdBuf[int'(byteSel)*8 +: 8] <= nextByte;
      if (stb.driveBit) begin
        driveQ <= ~rspWord[0];
        rspSh  <= rspWord >> 1;
      end
      if (stb.relLine) driveQ <= 1'b0;
    end
  end

  assign cmdIndex = cmdBuf;
  assign driveLow = driveQ;

endmodule

// File: rtl/spi3w_cmd_slave.sv
`timescale 1ns/1ps
module spi3w_cmd_slave
  import spi3w_pkg::*;
#(
  parameter int CMD_BYTES = 2,
  parameter int RSP_BYTES = 2,
  localparam int CMD_BITS = CMD_BYTES * 8,
  localparam int RSP_BITS = RSP_BYTES * 8,
  localparam int BYTE_W   = (CMD_BYTES > 1) ? $clog2(CMD_BYTES) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                csN,
  input  logic                sclk,
  input  logic                sdIn,
  output logic                lineDriveLow,
  output logic [CMD_BITS-1:0] cmdIndex,
  input  logic [RSP_BITS-1:0] rspData
);

  logic [2:0]        syncOut;
  logic              csS, sclkS, sdS;
  logic              csPrev, sclkPrev;
  logic              csActive, csStart, sclkRise, sclkFall;
  strobe_t           stb;
  logic [BYTE_W-1:0] byteSel;
  phase_e            phase;
  logic              driveQ;

  spi3w_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b111)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({sdIn, sclk, csN}),
    .dout (syncOut)
  );

  assign csS   = syncOut[0];
  assign sclkS = syncOut[1];
  assign sdS   = syncOut[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev   <= 1'b1;
      sclkPrev <= 1'b1;
    end else begin
      csPrev   <= csS;
      sclkPrev <= sclkS;
    end
  end

  assign csActive = ~csS;
  assign csStart  = csPrev & ~csS;
  assign sclkRise = sclkS & ~sclkPrev;
  assign sclkFall = ~sclkS & sclkPrev;

  spi3w_ctrl #(.CMD_BYTES(CMD_BYTES), .RSP_BITS(RSP_BITS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .csActive (csActive),
    .csStart  (csStart),
    .sclkRise (sclkRise),
    .sclkFall (sclkFall),
    .stb      (stb),
    .byteSel  (byteSel),
    .phase    (phase)
  );

  spi3w_dp #(.CMD_BYTES(CMD_BYTES), .RSP_BITS(RSP_BITS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .byteSel  (byteSel),
    .sdS      (sdS),
    .rspData  (rspData),
    .cmdIndex (cmdIndex),
    .driveLow (driveQ)
  );

  // Raw chip select gates the pull-down so a deselect frees the line at once
  assign lineDriveLow = driveQ & ~csN;

endmodule

// File: rtl/spi3w_cmd_slave_chk.sv
`timescale 1ns/1ps
module spi3w_cmd_slave_chk
  import spi3w_pkg::*;
#(
  parameter int CMD_BITS = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                csActive,
  input logic                csStart,
  input phase_e              phase,
  input logic                driveQ,
  input logic [CMD_BITS-1:0] cmdIndex
);

  AST_DESELECT_FREES: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |=> !driveQ) else $error("deselect kept line low"); // R7

  AST_CMD_PHASE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_CMD) |-> !driveQ) else $error("line pulled during command"); // R2

  AST_DRIVE_IN_RSP_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    driveQ |-> (phase == PH_RSP)) else $error("line pulled outside response"); // R4

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    csStart |=> (phase == PH_CMD && cmdIndex == '0)) else $error("start did not clear"); // R6

  AST_INDEX_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_RSP) |=> (phase != PH_RSP || $stable(cmdIndex))) else $error("index moved in response"); // R5

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DONE) |-> !driveQ) else $error("line pulled after response"); // R8

endmodule

bind spi3w_cmd_slave spi3w_cmd_slave_chk #(.CMD_BITS(CMD_BITS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .csActive (csActive),
  .csStart  (csStart),
  .phase    (phase),
  .driveQ   (driveQ),
  .cmdIndex (cmdIndex)
);

// File: tb/spi3w_cmd_slave_bench.sv
`timescale 1ns/1ps
module spi3w_cmd_slave_bench;

  localparam int CMD_BYTES = 2;
  localparam int RSP_BYTES = 2;
  localparam int CMD_BITS  = CMD_BYTES * 8;
  localparam int RSP_BITS  = RSP_BYTES * 8;
  localparam int HALF      = 8;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                csN = 1'b1;
  logic                sclk = 1'b1;
  logic                sdIn = 1'b1;
  logic                lineDriveLow;
  logic [CMD_BITS-1:0] cmdIndex;
  logic [RSP_BITS-1:0] rspData;

  int checks = 0;
  int errors = 0;
  bit doneFlag = 1'b0;

  always #10 clk = ~clk;

  // Register map model: computed from the index
  function automatic logic [RSP_BITS-1:0] mapF(input logic [CMD_BITS-1:0] i);
    return RSP_BITS'(i * 16'd40503) ^ RSP_BITS'(16'hA5C3);
  endfunction

  assign rspData = mapF(cmdIndex);

  spi3w_cmd_slave #(.CMD_BYTES(CMD_BYTES), .RSP_BYTES(RSP_BYTES)) u_spi3w_cmd_slave (
    .clk          (clk),
    .rstN         (rstN),
    .csN          (csN),
    .sclk         (sclk),
    .sdIn         (sdIn),
    .lineDriveLow (lineDriveLow),
    .cmdIndex     (cmdIndex),
    .rspData      (rspData)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendCmd(input logic [CMD_BITS-1:0] cmd, output bit pulled);
    pulled = 1'b0;
    for (int b = 0; b < CMD_BITS; b++) begin
      sclk = 1'b0; sdIn = cmd[b];
      tick(HALF);
      if (lineDriveLow) pulled = 1'b1;
      sclk = 1'b1;
      tick(HALF);
    end
  endtask

  task automatic readBits(input int n, input logic [31:0] junk, output logic [31:0] got);
    got = '0;
    for (int b = 0; b < n; b++) begin
      sclk = 1'b0; sdIn = junk[b % 32];
      tick(6);
      got[b] = ~lineDriveLow;
      tick(HALF - 6);
      sclk = 1'b1;
      tick(HALF);
    end
  endtask

  task automatic exchange(input logic [CMD_BITS-1:0] cmd, input logic [31:0] junk, input int extra);
    bit pulled;
    logic [31:0] got;
    csN = 1'b0;
    tick(HALF);
    check(cmdIndex == '0, "R6 index cleared at select", 32'(cmdIndex), 0);
    sendCmd(cmd, pulled);
    check(!pulled, "R2 line released while receiving", 32'(pulled), 0);
    check(cmdIndex == cmd, "R3 command index", 32'(cmdIndex), 32'(cmd));
    readBits(RSP_BITS, junk, got);
    check(got[RSP_BITS-1:0] == mapF(cmd), "R4 R1 response word", got, 32'(mapF(cmd)));
    check(cmdIndex == cmd, "R5 index unaffected by line input", 32'(cmdIndex), 32'(cmd));
    if (extra > 0) begin
      readBits(extra, junk, got);
      check(got == 32'hFFFF_FFFF >> (32 - extra) || extra == 32 && got == 32'hFFFF_FFFF,
            "R8 line released past response", got, 32'hFFFF_FFFF >> (32 - extra));
    end
    csN = 1'b1;
    sdIn = 1'b1;
    tick(HALF);
  endtask

  initial begin
    #3_000_000;
    if (!doneFlag) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [CMD_BITS-1:0] zc;
    bit pulled;
    tick(4);
    rstN = 1'b1;
    tick(4);
    check(lineDriveLow == 1'b0, "R10 line released after reset", 32'(lineDriveLow), 0);
    check(cmdIndex == '0, "R10 index zero after reset", 32'(cmdIndex), 0);

    // Corner commands, then a sweep with alternating junk on the line
    exchange(16'h0000, 32'hFFFF_FFFF, 8);
    exchange(16'hFFFF, 32'h0000_0000, 0);
    exchange(16'h0001, 32'hAAAA_AAAA, 3);
    exchange(16'h8000, 32'h5555_5555, 0);
    exchange(16'hA55A, 32'h1234_5678, 0);
    for (int k = 0; k < 24; k++) begin
      exchange(CMD_BITS'(k * 2731 + 17), 32'(k * 40503), (k % 3 == 0) ? 5 : 0);
    end

    // R7: abort in the middle of the first command byte
    csN = 1'b0;
    tick(HALF);
    for (int b = 0; b < 5; b++) begin
      sclk = 1'b0; sdIn = 1'b1; tick(HALF);
      sclk = 1'b1; tick(HALF);
    end
    csN = 1'b1;
    #1;
    check(lineDriveLow == 1'b0, "R7 released on deselect in command", 32'(lineDriveLow), 0);
    tick(HALF);
    exchange(16'h3C0F, 32'hF0F0_F0F0, 0);

    // R9 and R7: mid-response abort on a bit that pulls low
    zc = '0;
    for (int c = 0; c < 64; c++) begin
      if (mapF(CMD_BITS'(c + 100))[0] == 1'b0) begin
        zc = CMD_BITS'(c + 100);
        break;
      end
    end
    csN = 1'b0;
    tick(HALF);
    sendCmd(zc, pulled);
    sclk = 1'b0;
    tick(2);
    check(lineDriveLow == 1'b0, "R9 not before third edge", 32'(lineDriveLow), 0);
    tick(1);
    check(lineDriveLow == 1'b1, "R9 R1 low bit on third edge", 32'(lineDriveLow), 1);
    tick(2);
    csN = 1'b1;
    #1;
    check(lineDriveLow == 1'b0, "R7 released on deselect in response", 32'(lineDriveLow), 0);
    tick(HALF);
    sclk = 1'b1;
    tick(HALF);
    check(lineDriveLow == 1'b0, "R7 stays released", 32'(lineDriveLow), 0);
    exchange(zc, 32'h0, 4);

    doneFlag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule